// File: doc/BRIEF.md
# Receive Buffer Flow-Control Watermark Unit

This unit watches how much room is left in a 12 KB receive buffer. Free space is reported in 32-bit words, and the unit compares it with two thresholds that software programs in the same units. The upper threshold starts flow control, and its usual setting is 768 words. The lower threshold is an overrun alarm, and its usual setting is 64 words. The unit then decides what the MAC should do about congestion. On a full-duplex link with outbound flow control turned on, it asks for a PAUSE frame. On a half-duplex link, it forces carrier sense as backpressure.

When the buffer fills in full duplex, the unit sends one stop request carrying a large pause time. When the buffer drains again, it sends one resume request with zero pause time. In half duplex the forced carrier drops for a few cycles at regular intervals, so the line is never held continuously. The forced carrier also steps aside whenever the local transmitter has a frame waiting. Separately, when the MAC reports a received PAUSE, the unit holds the local transmitter for the requested number of pause quanta. The unit does not build or parse frames; it only makes the decisions.

Top module: `rxbuf_flow_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pause_req`, `pause_quanta`, `crs_force`, `tx_hold` and `ovr_flag` are all zero.
- R2: With `full_duplex`=1 and `tx_fc_en`=1, the unit may be in the idle state (no stop request outstanding). If a clock edge then samples `free_dw` <= `hi_wm`, `pause_req` is high for the following cycle with `pause_quanta` = XOFF_QUANTA (default 16'hFFFF). No further request is made while free space stays at or below `hi_wm`.
- R3: Once a stop request has been made, the first edge that samples `free_dw` > `hi_wm` (with the mode still enabled) makes `pause_req` high for the following cycle with `pause_quanta` = 0. The unit then returns to idle.
- R4: If `full_duplex`=0 or `tx_fc_en`=0 at an edge, `pause_req` is low in the following cycle and any outstanding stop request is forgotten, with no resume request sent. `pause_quanta` is zero whenever `pause_req` is low.
- R5: With `full_duplex`=0, count the consecutive edges k = 0, 1, 2, ... that sample `free_dw` <= `hi_wm`. After edge k, `crs_force` is high exactly when (k mod (BP_ON_CYC+BP_GAP_CYC)) < BP_ON_CYC (defaults 48 and 4) and `tx_pending` was low at that edge. An edge with `free_dw` > `hi_wm` drops `crs_force` and restarts the count.
- R6: An edge that samples `tx_pending`=1 makes `crs_force` low in the following cycle, while the gap count keeps running.
- R7: An edge that samples `full_duplex`=1 makes `crs_force` low in the following cycle.
- R8: With `full_duplex`=1 and `rx_fc_en`=1, an edge that samples `pause_rx_valid`=1 with quanta q>0 makes `tx_hold` high for exactly q*QUANT_CYC cycles (default QUANT_CYC=8), after which it falls. A new valid pulse reloads the count.
- R9: A received pause with q=0 makes `tx_hold` low in the following cycle, even if a hold was running.
- R10: An edge where `full_duplex`=0 or `rx_fc_en`=0 clears any running hold, so `tx_hold` is low in the following cycle, and a `pause_rx_valid` at that edge is ignored.
- R11: An edge that samples `free_dw` <= `ovr_wm` sets `ovr_flag`. The flag then stays set until an edge samples `ovr_clear`=1 while `free_dw` > `ovr_wm`; if both hold at the same edge, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | 1 = full-duplex link, 0 = half-duplex |
| tx_fc_en | input | 1 | Enables sending PAUSE requests |
| rx_fc_en | input | 1 | Enables honouring received PAUSE |
| free_dw | input | 12 | Free receive-buffer space in 32-bit words |
| hi_wm | input | 12 | Flow-control threshold in words |
| ovr_wm | input | 12 | Overrun-alarm threshold in words |
| tx_pending | input | 1 | Local frame waiting to transmit |
| pause_rx_valid | input | 1 | One-cycle strobe: a PAUSE was received |
| pause_rx_quanta | input | 16 | Pause time carried by that PAUSE |
| ovr_clear | input | 1 | Host clears the overrun flag |
| pause_req | output | 1 | One-cycle request to send a PAUSE |
| pause_quanta | output | 16 | Pause time for the requested PAUSE |
| crs_force | output | 1 | Forced carrier sense (half-duplex backpressure) |
| tx_hold | output | 1 | Hold the local transmitter |
| ovr_flag | output | 1 | Sticky overrun-risk flag |

## Verification
Suppose the stop/resume state were wrong. The first threshold crossing would then show it at `pause_req` and `pause_quanta` one cycle later: either a second stop request, a missing resume, or a resume sent after the mode was switched off. A fault in the gap counter moves the carrier drop away from every 52nd cycle, and that is visible within one backpressure period. A fault in the pause timer makes `tx_hold` fall a few cycles too early or too late, which shows when the first quantum runs out. The bench tracks all of this cycle by cycle with a random walk of free space around both thresholds.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
    localparam int BUF_BYTES   = 12288;
    localparam int BUF_DW      = BUF_BYTES / 4;
    localparam int FREE_W      = $clog2(BUF_DW + 1);
    localparam int HI_WM_DEF   = 3072 / 4;
    localparam int OVR_WM_DEF  = 256 / 4;
    localparam int QUANTA_W    = 16;

    typedef logic [FREE_W-1:0]   dw_t;
    typedef logic [QUANTA_W-1:0] quanta_t;
endpackage

// File: rtl/rxfc_pause_req.sv
module rxfc_pause_req
    import rxfc_pkg::*;
#(
    parameter quanta_t XOFF_QUANTA = 16'hFFFF
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  logic    below_hi,
    output logic    pause_req,
    output quanta_t pause_quanta
);
    typedef struct packed {
        logic    armed;
        logic    req;
        quanta_t quanta;
    } preq_t;

    preq_t s_q, s_d;

    always_comb begin
        s_d        = s_q;
        s_d.req    = 1'b0;
        s_d.quanta = '0;
        if (!enable) begin
            s_d.armed = 1'b0;
        end else if (!s_q.armed && below_hi) begin
            s_d.armed  = 1'b1;
            s_d.req    = 1'b1;
            s_d.quanta = XOFF_QUANTA;
        end else if (s_q.armed && !below_hi) begin
            s_d.armed  = 1'b0;
            s_d.req    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pause_req    = s_q.req;
    assign pause_quanta = s_q.quanta;

    AST_PAUSE_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pause_req); // R4
    AST_XOFF_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && pause_quanta != '0) |-> $past(below_hi)); // R2
    AST_XON_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && pause_quanta == '0) |-> !$past(below_hi)); // R3
    AST_QUANTA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_req |-> pause_quanta == '0); // R4
endmodule

// File: rtl/rxfc_backpressure.sv
module rxfc_backpressure #(
    parameter int ON_CYC  = 48,
    parameter int GAP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tx_pending,
    output logic crs_force
);
    localparam int PERIOD = ON_CYC + GAP_CYC;
    localparam int CNT_W  = $clog2(PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             crs;
    } bp_t;

    bp_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.crs = active && !tx_pending && (s_q.cnt < CNT_W'(ON_CYC));
        if (!active)                            s_d.cnt = '0;
        else if (s_q.cnt == CNT_W'(PERIOD - 1)) s_d.cnt = '0;
        else                                    s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign crs_force = s_q.crs;

    AST_CRS_YIELDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pending |=> !crs_force); // R6
    AST_CRS_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !crs_force); // R5
endmodule

// File: rtl/rxfc_pause_timer.sv
module rxfc_pause_timer
    import rxfc_pkg::*;
#(
    parameter int QUANT_CYC = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  logic    load,
    input  quanta_t load_quanta,
    output logic    tx_hold
);
    localparam int SUB_W = (QUANT_CYC > 1) ? $clog2(QUANT_CYC) : 1;

    typedef struct packed {
        quanta_t          left;
        logic [SUB_W-1:0] sub;
    } tmr_t;

    tmr_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d = '0;
        end else if (load) begin
            s_d.left = load_quanta;
            s_d.sub  = '0;
        end else if (s_q.left != '0) begin
            if (s_q.sub == SUB_W'(QUANT_CYC - 1)) begin
                s_d.sub  = '0;
                s_d.left = s_q.left - 1'b1;
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_hold = (s_q.left != '0);

    AST_ZERO_QUANTA_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load && load_quanta == '0) |=> !tx_hold); // R9
    AST_HOLD_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tx_hold); // R10
    AST_HOLD_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_hold && !(enable && load)) |=> !tx_hold); // R8
endmodule

// File: rtl/rxbuf_flow_ctrl.sv
module rxbuf_flow_ctrl
    import rxfc_pkg::*;
#(
    parameter quanta_t XOFF_QUANTA = 16'hFFFF,
    parameter int      BP_ON_CYC   = 48,
    parameter int      BP_GAP_CYC  = 4,
    parameter int      QUANT_CYC   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                full_duplex,
    input  logic                tx_fc_en,
    input  logic                rx_fc_en,
    input  logic [FREE_W-1:0]   free_dw,
    input  logic [FREE_W-1:0]   hi_wm,
    input  logic [FREE_W-1:0]   ovr_wm,
    input  logic                tx_pending,
    input  logic                pause_rx_valid,
    input  logic [QUANTA_W-1:0] pause_rx_quanta,
    input  logic                ovr_clear,
    output logic                pause_req,
    output logic [QUANTA_W-1:0] pause_quanta,
    output logic                crs_force,
    output logic                tx_hold,
    output logic                ovr_flag
);
    logic below_hi, at_ovr;
    logic ovr_d, ovr_q;

    assign below_hi = (free_dw <= hi_wm);
    assign at_ovr   = (free_dw <= ovr_wm);

    rxfc_pause_req #(.XOFF_QUANTA(XOFF_QUANTA)) u_preq (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (full_duplex && tx_fc_en),
        .below_hi     (below_hi),
        .pause_req    (pause_req),
        .pause_quanta (pause_quanta)
    );

    rxfc_backpressure #(.ON_CYC(BP_ON_CYC), .GAP_CYC(BP_GAP_CYC)) u_bp (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (!full_duplex && below_hi),
        .tx_pending (tx_pending),
        .crs_force  (crs_force)
    );

    rxfc_pause_timer #(.QUANT_CYC(QUANT_CYC)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (full_duplex && rx_fc_en),
        .load        (pause_rx_valid),
        .load_quanta (pause_rx_quanta),
        .tx_hold     (tx_hold)
    );

    always_comb begin
        ovr_d = ovr_q;
        if (at_ovr)         ovr_d = 1'b1;
        else if (ovr_clear) ovr_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    assign ovr_flag = ovr_q;

    AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        at_ovr |=> ovr_flag); // R11
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clear) |=> ovr_flag); // R11
    AST_NO_CRS_FULL_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |=> !crs_force); // R7
endmodule

// File: tb/sim_rxbuf_flow_ctrl.sv
`timescale 1ns/1ps
module sim_rxbuf_flow_ctrl;
    import rxfc_pkg::*;

    localparam int ON   = 48;
    localparam int GAP  = 4;
    localparam int PER  = ON + GAP;
    localparam int QC   = 8;
    localparam int XOFF = 16'hFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_duplex = 1'b0, tx_fc_en = 1'b0, rx_fc_en = 1'b0;
    logic [FREE_W-1:0] free_dw = FREE_W'(BUF_DW);
    logic [FREE_W-1:0] hi_wm = FREE_W'(HI_WM_DEF);
    logic [FREE_W-1:0] ovr_wm = FREE_W'(OVR_WM_DEF);
    logic tx_pending = 1'b0, pause_rx_valid = 1'b0, ovr_clear = 1'b0;
    logic [QUANTA_W-1:0] pause_rx_quanta = '0;
    logic pause_req, crs_force, tx_hold, ovr_flag;
    logic [QUANTA_W-1:0] pause_quanta;

    int checks = 0;
    int errors = 0;

    int m_armed, m_preq, m_pq, m_cnt, m_crs, m_left, m_sub, m_ovr;
    int free_i;

    always #2.5 clk = ~clk;

    rxbuf_flow_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .tx_fc_en(tx_fc_en),
        .rx_fc_en(rx_fc_en), .free_dw(free_dw), .hi_wm(hi_wm), .ovr_wm(ovr_wm),
        .tx_pending(tx_pending), .pause_rx_valid(pause_rx_valid),
        .pause_rx_quanta(pause_rx_quanta), .ovr_clear(ovr_clear),
        .pause_req(pause_req), .pause_quanta(pause_quanta), .crs_force(crs_force),
        .tx_hold(tx_hold), .ovr_flag(ovr_flag)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int next_crs(input int fd, input int below, input int pend, input int cnt);
        return (!fd && below && !pend && (cnt < ON)) ? 1 : 0;
    endfunction

    function automatic int next_cnt(input int fd, input int below, input int cnt);
        return (!fd && below) ? ((cnt + 1) % PER) : 0;
    endfunction

    // Advance the reference by one edge using the inputs currently applied
    task automatic model_edge();
        int below, fdtx, fdrx;
        below = (int'(free_dw) <= int'(hi_wm));
        fdtx  = full_duplex && tx_fc_en;
        fdrx  = full_duplex && rx_fc_en;
        m_preq = 0; m_pq = 0;
        if (!fdtx) m_armed = 0;
        else if (!m_armed && below) begin m_armed = 1; m_preq = 1; m_pq = XOFF; end
        else if (m_armed && !below) begin m_armed = 0; m_preq = 1; m_pq = 0; end
        m_crs = next_crs(full_duplex, below, tx_pending, m_cnt);
        m_cnt = next_cnt(full_duplex, below, m_cnt);
        if (!fdrx) begin m_left = 0; m_sub = 0; end
        else if (pause_rx_valid) begin m_left = pause_rx_quanta; m_sub = 0; end
        else if (m_left != 0) begin
            if (m_sub == QC - 1) begin m_sub = 0; m_left--; end
            else m_sub++;
        end
        if (int'(free_dw) <= int'(ovr_wm)) m_ovr = 1;
        else if (ovr_clear) m_ovr = 0;
    endtask

    task automatic step();
        string tp, tc, th;
        int fd_i, pend_i, zload;
        fd_i   = full_duplex;
        pend_i = tx_pending;
        zload  = pause_rx_valid && (pause_rx_quanta == 0);
        tp = (full_duplex && tx_fc_en) ? "R2" : "R4";
        th = (full_duplex && rx_fc_en) ? (zload ? "R9" : "R8") : "R10";
        @(posedge clk);
        model_edge();
        #1;
        if (tp == "R2" && m_preq && m_pq == 0) tp = "R3";
        tc = fd_i ? "R7" : (pend_i ? "R6" : "R5");
        check(tp, "pause_req", pause_req, m_preq);
        check(tp, "pause_quanta", pause_quanta, m_pq);
        check(tc, "crs_force", crs_force, m_crs);
        check(th, "tx_hold", tx_hold, (m_left != 0) ? 1 : 0);
        check("R11", "ovr_flag", ovr_flag, m_ovr);
    endtask

    task automatic walk_free(input int spread);
        free_i = free_i + int'($urandom_range(0, 2 * spread)) - spread;
        if (free_i < 0) free_i = 0;
        if (free_i > BUF_DW) free_i = BUF_DW;
        free_dw = FREE_W'(free_i);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_armed = 0; m_preq = 0; m_pq = 0; m_cnt = 0; m_crs = 0;
        m_left = 0; m_sub = 0; m_ovr = 0;
        free_i = BUF_DW;
        full_duplex = 1'b1; tx_fc_en = 1'b1; rx_fc_en = 1'b1;
        free_dw = '0; pause_rx_valid = 1'b1; pause_rx_quanta = 16'd5; tx_pending = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "pause_req in reset", pause_req, 0);
        check("R1", "pause_quanta in reset", pause_quanta, 0);
        check("R1", "crs_force in reset", crs_force, 0);
        check("R1", "tx_hold in reset", tx_hold, 0);
        check("R1", "ovr_flag in reset", ovr_flag, 0);
        free_dw = FREE_W'(BUF_DW); pause_rx_valid = 1'b0; pause_rx_quanta = '0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1", "pause_req after reset", pause_req, 0);
        check("R1", "ovr_flag after reset", ovr_flag, 0);

        // Directed R2/R3: one XOFF on crossing, one XON on recovery
        free_dw = FREE_W'(HI_WM_DEF + 1); step();
        free_dw = FREE_W'(HI_WM_DEF);     step();
        check("R2", "xoff issued at threshold", pause_req, 1);
        check("R2", "xoff quanta", pause_quanta, XOFF);
        free_dw = FREE_W'(HI_WM_DEF - 10); step();
        check("R2", "no repeat xoff", pause_req, 0);
        free_dw = FREE_W'(HI_WM_DEF + 1); step();
        check("R3", "xon issued", pause_req, 1);
        check("R3", "xon quanta zero", pause_quanta, 0);
        // Directed R4: disabling forgets armed state
        free_dw = FREE_W'(100); step();
        tx_fc_en = 1'b0; free_dw = FREE_W'(2000); step();
        check("R4", "no xon when disabled", pause_req, 0);
        tx_fc_en = 1'b1; step();
        check("R4", "still silent after re-enable", pause_req, 0);

        // Directed R8/R9: hold length and zero-quanta release
        pause_rx_valid = 1'b1; pause_rx_quanta = 16'd3; step();
        pause_rx_valid = 1'b0;
        for (int i = 0; i < 3 * QC - 1; i++) step();
        check("R8", "hold before expiry", tx_hold, 1);
        step();
        check("R8", "hold expired", tx_hold, 0);
        pause_rx_valid = 1'b1; pause_rx_quanta = 16'd40; step();
        pause_rx_quanta = 16'd0; step();
        check("R9", "zero quanta release", tx_hold, 0);
        pause_rx_valid = 1'b0;

        // Directed R10: pause ignored when receive flow control is off
        rx_fc_en = 1'b0; pause_rx_valid = 1'b1; pause_rx_quanta = 16'd9; step();
        check("R10", "pause ignored", tx_hold, 0);
        pause_rx_valid = 1'b0; rx_fc_en = 1'b1;

        // Directed R5/R6: backpressure pattern and yield to local traffic
        full_duplex = 1'b0; free_dw = FREE_W'(200);
        for (int k = 0; k < PER + 3; k++) step();
        tx_pending = 1'b1; step();
        check("R6", "crs drops for pending frame", crs_force, 0);
        tx_pending = 1'b0;
        for (int k = 0; k < 10; k++) step();

        // Directed R11: set wins over clear, clear works when above
        free_dw = FREE_W'(OVR_WM_DEF); ovr_clear = 1'b1; step();
        check("R11", "set beats clear", ovr_flag, 1);
        free_dw = FREE_W'(OVR_WM_DEF + 1); ovr_clear = 1'b0; step();
        check("R11", "sticky", ovr_flag, 1);
        ovr_clear = 1'b1; step();
        check("R11", "cleared", ovr_flag, 0);
        ovr_clear = 1'b0;
        free_i = HI_WM_DEF;

        // Random phases
        for (int ph = 0; ph < 24; ph++) begin
            full_duplex = ph[0];
            tx_fc_en = ($urandom_range(0, 3) != 0);
            rx_fc_en = ($urandom_range(0, 3) != 0);
            if (ph % 6 == 5) free_i = OVR_WM_DEF + 5;
            else if (ph % 3 == 0) free_i = HI_WM_DEF;
            for (int c = 0; c < 600; c++) begin
                walk_free((ph % 6 == 5) ? 8 : 20);
                tx_pending = ($urandom_range(0, 9) == 0);
                pause_rx_valid = ($urandom_range(0, 99) == 0);
                pause_rx_quanta = QUANTA_W'($urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 20));
                ovr_clear = ($urandom_range(0, 30) == 0);
                step();
            end
        end
        pause_rx_valid = 1'b0; ovr_clear = 1'b0; tx_pending = 1'b0;
        step();
        summary();
        $finish;
    end
endmodule